// File: doc/BRIEF.md
# MMIO Range-to-Port Address Router

The router decides which of eight downstream ports serves a 32-bit memory-mapped I/O request address. Software programs four directed windows, each sending one address range to a chosen port, and one distributed window, which is cut into eight equal consecutive slices with one slice per port. Every window is described by three 32-bit registers (base, mask, route), written and read through a plain register port.

Each accepted request produces a registered decode one cycle later: a hit flag, a miss flag and a 3-bit port number. Directed windows override the distributed window. Among directed windows the one with the lowest index wins. No payload passes through the block, and requests may be issued on every cycle.

Top module: `mmio_port_router`

## Requirements
- R1: After reset every register reads as zero, and every request decodes as a miss with port 0.
- R2: Register map. Directed window i (i = 0..3) keeps its base at 0x300 + 0x18*i, its mask at that address + 0x08 and its route at that address + 0x10. The distributed window keeps base, mask and route at 0x360, 0x368 and 0x370. A read returns the last value written to that register. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: Bit 0 of a base register enables its window. A window whose enable bit is clear never matches.
- R4: A window's start is its base with bit 0 cleared. An enabled window matches an address when (addr AND mask) equals (start AND mask).
- R5: When a directed window decides the result, the port is bits [2:0] of its route register. The upper route bits are ignored.
- R6: When several directed windows match, the one with the lowest index decides.
- R7: A matching directed window overrides a matching distributed window.
- R8: For a distributed hit, let slice = (NOT mask) / 8 and off = addr − start. The port is off / (slice + 1), capped at 7.
- R9: When no window matches, miss = 1, hit = 0 and port = 0. On a hit, hit = 1 and miss = 0.
- R10: req_ready_o is always 1. A request presented with req_valid_i at clock edge N has its result, with rsp_valid_o = 1, after edge N+1. rsp_valid_o is 0 in the cycle after a cycle with no request. Requests on consecutive cycles are all decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Always 1 |
| req_addr_i | input | 32 | Request address |
| rsp_valid_o | output | 1 | Decode result valid |
| rsp_hit_o | output | 1 | Some enabled window matched |
| rsp_miss_o | output | 1 | No window matched |
| rsp_port_o | output | 3 | Selected downstream port |

## Verification
The hardest case to reach is an address that several windows claim at once, because the priority rules only show there. The bench therefore programs two directed windows that partly overlap each other and sit inside the distributed window, plus a disabled window over unused space. It then sweeps every word across the whole distributed span and its edges, so that each priority case, each slice boundary and each port are visited back-to-back. A second configuration with a tiny distributed span sweeps byte by byte, so that each slice is two bytes wide and every slice edge is covered.

// File: rtl/mmio_rt_pkg.sv
package mmio_rt_pkg;
  localparam int unsigned REG_AW     = 12;
  localparam int unsigned DIR_OFS0   = 'h300;
  localparam int unsigned DIR_STRIDE = 'h18;
  localparam int unsigned DIST_OFS   = 'h360;
  localparam int unsigned FLD_STRIDE = 'h08;

  // fld: 0 base, 1 mask, 2 route
  function automatic logic [REG_AW-1:0] dir_ofs(input int unsigned idx, input int unsigned fld);
    return REG_AW'(DIR_OFS0 + idx * DIR_STRIDE + fld * FLD_STRIDE);
  endfunction

  function automatic logic [REG_AW-1:0] dist_ofs(input int unsigned fld);
    return REG_AW'(DIST_OFS + fld * FLD_STRIDE);
  endfunction
endpackage

// File: rtl/rt_regfile.sv
module rt_regfile
  import mmio_rt_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned NUM_DIR = 4,
  parameter int unsigned PORT_W  = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [REG_AW-1:0]                 addr_i,
  input  logic [AW-1:0]                     wdata_i,
  output logic [AW-1:0]                     rdata_o,
  output logic [NUM_DIR-1:0][AW-1:0]        dir_base_o,
  output logic [NUM_DIR-1:0][AW-1:0]        dir_mask_o,
  output logic [NUM_DIR-1:0][PORT_W-1:0]    dir_route_o,
  output logic [AW-1:0]                     dist_base_o,
  output logic [AW-1:0]                     dist_mask_o
);
  localparam int unsigned NFLD = 3;

  logic [NUM_DIR-1:0][NFLD-1:0][AW-1:0] dir_q;
  logic [NFLD-1:0][AW-1:0]              dist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      dist_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NUM_DIR; i++)
        for (int f = 0; f < NFLD; f++)
          if (addr_i == dir_ofs(i, f)) dir_q[i][f] <= wdata_i;
      for (int f = 0; f < NFLD; f++)
        if (addr_i == dist_ofs(f)) dist_q[f] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_DIR; i++)
      for (int f = 0; f < NFLD; f++)
        if (addr_i == dir_ofs(i, f)) rdata_o = dir_q[i][f];
    for (int f = 0; f < NFLD; f++)
      if (addr_i == dist_ofs(f)) rdata_o = dist_q[f];
  end

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_out
    assign dir_base_o[g]  = dir_q[g][0];
    assign dir_mask_o[g]  = dir_q[g][1];
    assign dir_route_o[g] = dir_q[g][2][PORT_W-1:0];
  end
  assign dist_base_o = dist_q[0];
  assign dist_mask_o = dist_q[1];

  // R2
  wr_rd_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == dist_ofs(2)) |=>
      (addr_i != dist_ofs(2) || rdata_o == $past(wdata_i)));
endmodule

// File: rtl/rt_window_match.sv
module rt_window_match #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  output logic          hit_o
);
  logic [AW-1:0] start;
  assign start = {base_i[AW-1:1], 1'b0};
  assign hit_o = base_i[0] && ((addr_i & mask_i) == (start & mask_i));
endmodule

// File: rtl/rt_dist_slicer.sv
module rt_dist_slicer #(
  parameter int unsigned AW     = 32,
  parameter int unsigned PORT_W = 3
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     mask_i,
  output logic [PORT_W-1:0] idx_o
);
  localparam int unsigned NPORT = 1 << PORT_W;
  localparam int unsigned XW    = AW + PORT_W;

  logic [AW-1:0] start, offset, span, slice_m1;
  logic [XW-1:0] step_x, off_x;

  assign start    = {base_i[AW-1:1], 1'b0};
  assign offset   = base_i[0] ? (addr_i - start) : '0;
  assign span     = ~mask_i;
  assign slice_m1 = span / AW'(NPORT);
  assign step_x   = XW'(slice_m1) + XW'(1);
  assign off_x    = XW'(offset);

  // Slice index = number of slice boundaries at or below the offset; last slice absorbs the rest.
  always_comb begin
    idx_o = '0;
    for (int r = 1; r < NPORT; r++)
      if (off_x >= step_x * XW'(r)) idx_o = idx_o + PORT_W'(1);
  end
endmodule

// File: rtl/mmio_port_router.sv
module mmio_port_router
  import mmio_rt_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned NUM_DIR = 4,
  parameter int unsigned PORT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [AW-1:0]     reg_wdata_i,
  output logic [AW-1:0]     reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic [PORT_W-1:0] rsp_port_o
);
  logic [NUM_DIR-1:0][AW-1:0]     dir_base, dir_mask;
  logic [NUM_DIR-1:0][PORT_W-1:0] dir_route;
  logic [AW-1:0]                  dist_base, dist_mask;
  logic [NUM_DIR-1:0]             dir_hit;
  logic                           dist_hit, dir_any;
  logic [PORT_W-1:0]              dir_port, slice_idx, nxt_port;

  rt_regfile #(.AW(AW), .NUM_DIR(NUM_DIR), .PORT_W(PORT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .dir_base_o  (dir_base),
    .dir_mask_o  (dir_mask),
    .dir_route_o (dir_route),
    .dist_base_o (dist_base),
    .dist_mask_o (dist_mask)
  );

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    rt_window_match #(.AW(AW)) u_match (
      .addr_i (req_addr_i),
      .base_i (dir_base[g]),
      .mask_i (dir_mask[g]),
      .hit_o  (dir_hit[g])
    );
  end

  rt_window_match #(.AW(AW)) u_dist_match (
    .addr_i (req_addr_i),
    .base_i (dist_base),
    .mask_i (dist_mask),
    .hit_o  (dist_hit)
  );

  rt_dist_slicer #(.AW(AW), .PORT_W(PORT_W)) u_slicer (
    .addr_i (req_addr_i),
    .base_i (dist_base),
    .mask_i (dist_mask),
    .idx_o  (slice_idx)
  );

  // Scan downward so the lowest matching index is the last to assign.
  always_comb begin
    dir_any  = 1'b0;
    dir_port = '0;
    for (int i = NUM_DIR - 1; i >= 0; i--)
      if (dir_hit[i]) begin
        dir_any  = 1'b1;
        dir_port = dir_route[i];
      end
  end

  assign nxt_port    = dir_any ? dir_port : (dist_hit ? slice_idx : '0);
  assign req_ready_o = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_port_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o  <= dir_any | dist_hit;
        rsp_miss_o <= ~(dir_any | dist_hit);
        rsp_port_o <= nxt_port;
      end
    end
  end

  logic [PORT_W-1:0] route0;
  assign route0 = dir_route[0];

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R10
  no_rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R9
  miss_port_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_miss_o) |-> (rsp_port_o == '0 && !rsp_hit_o));

  // R6
  dir0_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dir_hit[0]) |=> (rsp_hit_o && rsp_port_o == $past(route0)));

  // R7
  dist_slice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dist_hit && dir_hit == '0) |=> (rsp_hit_o && rsp_port_o == $past(slice_idx)));
endmodule

// File: tb/sim_mmio_port_router.sv
module sim_mmio_port_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [2:0]  rsp_port;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] sh_base [4];
  logic [31:0] sh_mask [4];
  logic [31:0] sh_route[4];
  logic [31:0] d_base, d_mask, d_route;

  always #4 clk = ~clk;

  mmio_port_router u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss), .rsp_port_o(rsp_port)
  );

  function automatic logic [11:0] ofs_dir(input int i, input int f);
    return 12'(32'h300 + i * 32'h18 + f * 8);
  endfunction
  function automatic logic [11:0] ofs_dist(input int f);
    return 12'(32'h360 + f * 8);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic set_dir(input int i, input logic [31:0] b, input logic [31:0] m, input logic [31:0] r);
    reg_wr(ofs_dir(i, 0), b); reg_wr(ofs_dir(i, 1), m); reg_wr(ofs_dir(i, 2), r);
    sh_base[i] = b; sh_mask[i] = m; sh_route[i] = r;
  endtask

  task automatic set_dist(input logic [31:0] b, input logic [31:0] m, input logic [31:0] r);
    reg_wr(ofs_dist(0), b); reg_wr(ofs_dist(1), m); reg_wr(ofs_dist(2), r);
    d_base = b; d_mask = m; d_route = r;
  endtask

  // Expected decode, computed from the requirement text
  task automatic model(input logic [31:0] a, output logic hit, output logic [2:0] port);
    logic [31:0] st, off, sl, q;
    hit = 1'b0; port = '0;
    for (int i = 0; i < 4; i++) begin
      st = sh_base[i] & 32'hFFFF_FFFE;
      if (!hit && sh_base[i][0] && ((a & sh_mask[i]) == (st & sh_mask[i]))) begin
        hit = 1'b1; port = sh_route[i][2:0];
      end
    end
    st = d_base & 32'hFFFF_FFFE;
    if (!hit && d_base[0] && ((a & d_mask) == (st & d_mask))) begin
      off = a - st;
      sl  = (~d_mask) / 8;
      q   = off / (sl + 1);
      if (q > 7) q = 7;
      hit = 1'b1; port = q[2:0];
    end
  endtask

  task automatic chk_rsp(input logic [31:0] a, input string tag);
    logic eh; logic [2:0] ep;
    model(a, eh, ep);
    check(rsp_valid == 1'b1, "R10 rsp_valid", 32'(rsp_valid), 32'd1);
    check(rsp_hit == eh && rsp_miss == !eh, {tag, " R9 hit/miss"}, {30'd0, rsp_hit, rsp_miss}, {30'd0, eh, !eh});
    check(rsp_port == ep, {tag, " port"}, 32'(rsp_port), 32'(ep));
  endtask

  // Back-to-back sweep: the result of a request is checked while the next one is driven
  task automatic sweep(input logic [31:0] lo, input int n, input logic [31:0] step, input string tag);
    logic pend; logic [31:0] pa;
    pend = 1'b0; pa = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pend) chk_rsp(pa, tag);
      req_valid = 1'b1;
      req_addr  = lo + 32'(k) * step;
      pa = req_addr;
      pend = 1'b1;
    end
    @(negedge clk);
    chk_rsp(pa, tag);
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 idle after burst", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin sh_base[i] = '0; sh_mask[i] = '0; sh_route[i] = '0; end
    d_base = '0; d_mask = '0; d_route = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 4; i++)
      for (int f = 0; f < 3; f++) reg_chk(ofs_dir(i, f), 32'd0, "R1 dir reg after reset");
    for (int f = 0; f < 3; f++) reg_chk(ofs_dist(f), 32'd0, "R1 dist reg after reset");
    check(req_ready == 1'b1, "R10 ready", 32'(req_ready), 32'd1);
    sweep(32'h0000_0000, 8, 32'h2000_0000, "R1 decode after reset");

    // R2: unmapped write ignored, reads zero
    reg_wr(12'h304, 32'hFFFF_FFFF);
    reg_wr(12'h378, 32'hFFFF_FFFF);
    reg_chk(12'h304, 32'd0, "R2 unmapped read");
    reg_chk(12'h378, 32'd0, "R2 unmapped read");
    reg_chk(ofs_dir(0, 0), 32'd0, "R2 unmapped write left dir0 base");
    reg_chk(ofs_dist(1), 32'd0, "R2 unmapped write left dist mask");

    // Config A: dist 0x8000_0000..0FFF, overlapping directed windows, one disabled
    set_dist(32'h8000_0001, 32'hFFFF_F000, 32'h0000_0006);
    set_dir(0, 32'h8000_0401, 32'hFFFF_FF00, 32'h0000_0005);
    set_dir(1, 32'h8000_0401, 32'hFFFF_FE00, 32'h0000_0003);
    set_dir(2, 32'h9000_0000, 32'hFFFF_FF00, 32'h0000_0001);
    set_dir(3, 32'hA000_0001, 32'hFFFF_FFF0, 32'hFFFF_FF0F);

    for (int i = 0; i < 4; i++) begin
      reg_chk(ofs_dir(i, 0), sh_base[i],  "R2 dir base readback");
      reg_chk(ofs_dir(i, 1), sh_mask[i],  "R2 dir mask readback");
      reg_chk(ofs_dir(i, 2), sh_route[i], "R2 dir route readback");
    end
    reg_chk(ofs_dist(0), d_base,  "R2 dist base readback");
    reg_chk(ofs_dist(1), d_mask,  "R2 dist mask readback");
    reg_chk(ofs_dist(2), d_route, "R2 dist route readback");
    reg_chk(12'h304, 32'd0, "R2 unmapped read");

    sweep(32'h7FFF_FF00, 1152, 32'd4, "R4 R6 R7 R8 dist span");
    sweep(32'h9000_0000, 64, 32'd4, "R3 disabled window");
    sweep(32'hA000_0000, 48, 32'd1, "R5 route low bits");

    // R3: enabling the window makes the same addresses hit
    set_dir(2, 32'h9000_0001, 32'hFFFF_FF00, 32'h0000_0001);
    sweep(32'h9000_0000, 64, 32'd4, "R3 enabled window");

    // Config B: tiny dist span, 2-byte slices
    set_dir(0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0);
    set_dir(1, 32'h4000_0019, 32'hFFFF_FFFC, 32'h0000_0002);
    set_dist(32'h4000_0011, 32'hFFFF_FFF0, 32'h0);
    sweep(32'h4000_0000, 64, 32'd1, "R7 R8 small slices");

    // R3: disabling the distributed window turns its span into misses
    set_dist(32'h4000_0010, 32'hFFFF_FFF0, 32'h0);
    sweep(32'h4000_0000, 40, 32'd1, "R3 R9 dist disabled");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule